// File: doc/BRIEF.md
# Timer Capture, Compare and Pulse-Width Channel

This block is one channel that sits beside a free-running timer. It holds a single timer-wide data register and a small control register whose 4-bit mode field decides what the channel does. In a capture mode it copies the external timer count into the data register when a qualifying edge arrives on the pin input. In a compare mode it watches for the timer reaching the data register and then toggles, sets or clears the pin latch, raises the flag, or, in the special-event mode, also pulses a timer-reset strobe. In a pulse-width mode it drives the pin high for a duty time built from a separate duty register and two fine bits in the control register.

Software reaches the channel through a byte-wide write port and a registered read port. The flag stays set until the flag-clear input is pulsed. The timers, the interrupt controller and pin direction are outside the block.

Top module: `tmr_event_channel`

## Requirements
- R1: After reset every register reads 0, and pin_o, flag_o and tmr_rst_o are 0.
- R2: Address 0 is control (bits 3:0 mode, bits 5:4 low duty bits, bits 7:6 ignore writes and read 0), address 1 is the 8-bit duty register, address 2 the low and address 3 the high byte of the data register; rd_data_o shows the addressed register one clock after rd_addr_i.
- R3: Mode 0100 captures on each falling pin edge and 0101 on each rising edge; 0110 captures on every 4th and 0111 on every 16th rising edge. The pin passes through a two-flop synchronizer first.
- R4: The capture prescale count restarts from zero whenever the mode field changes.
- R5: A capture copies tmr_i into the data register and sets flag_o; flag_o holds until a flag_clr_i pulse.
- R6: Mode 0010 toggles pin_o and sets flag_o when tmr_i becomes equal to the data register; a timer that stays equal causes no further action.
- R7: Entering mode 1000 drives pin_o low and a match drives it high; entering mode 1001 drives pin_o high and a match drives it low; both set flag_o.
- R8: Modes 1010 and 1011 set flag_o on a match and leave pin_o unchanged; in 1011 a channel built with HAS_SPECIAL=1 also raises tmr_rst_o for exactly one clock, while HAS_SPECIAL=0 never raises it.
- R9: Modes 11xx run the pulse-width output: duty D = {duty register, control bits 5:4}; after a per_i clock pin_o is high for exactly D clocks (a fine count advances every clock and tb_i advances each time it wraps after 4), D=0 keeps it low and D beyond the period keeps it high.
- R10: D is latched at per_i; a duty write during a period takes effect only from the next per_i.
- R11: Mode codes 0000, 0001 and 0011 disable the channel: pin_o goes low, compares and captures do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_i | input | TMR_W | Running timer count |
| tb_i | input | 8 | Pulse-width timebase count |
| per_i | input | 1 | Timebase period-match strobe |
| pin_i | input | 1 | Asynchronous pin level for capture |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | 8 | Registered read data |
| flag_clr_i | input | 1 | Clears the event flag |
| pin_o | output | 1 | Pin output level |
| flag_o | output | 1 | Event flag |
| tmr_rst_o | output | 1 | One-clock timer-reset strobe |

## Verification
The bench builds two copies side by side on the same stimulus: one with the default parameters (16-bit timer, two synchronizer stages, divide-by-4 and divide-by-16 prescale, special event enabled) and one with HAS_SPECIAL=0. The second copy makes the contrast of R8 observable at the ports, since only the first may raise the timer-reset strobe on a 1011 match. Register reads go through a scoreboard queue, and the pulse-width checks count high clocks across whole periods.

// File: rtl/tec_pkg.sv
package tec_pkg;
  typedef enum logic [1:0] {FN_OFF, FN_CAP, FN_CMP, FN_PWM} fn_e;

  localparam logic [3:0] M_CAP_FALL = 4'b0100;
  localparam logic [3:0] M_CAP_RISE = 4'b0101;
  localparam logic [3:0] M_CAP_LO   = 4'b0110;
  localparam logic [3:0] M_CAP_HI   = 4'b0111;
  localparam logic [3:0] M_CMP_TOG  = 4'b0010;
  localparam logic [3:0] M_CMP_SET  = 4'b1000;
  localparam logic [3:0] M_CMP_CLR  = 4'b1001;
  localparam logic [3:0] M_CMP_FLAG = 4'b1010;
  localparam logic [3:0] M_CMP_EVT  = 4'b1011;

  function automatic fn_e mode_fn(input logic [3:0] m);
    if (m[3:2] == 2'b11) return FN_PWM;
    else if (m[3:2] == 2'b01) return FN_CAP;
    else if (m[3] || (m == M_CMP_TOG)) return FN_CMP;
    else return FN_OFF;
  endfunction
endpackage

// File: rtl/tec_edge_sync.sv
module tec_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES flops of synchronizer plus one for the previous level
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tec_capture.sv
module tec_capture
  import tec_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] mode_i,
  input  logic       mode_chg_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       evt_o
);
  localparam int PRE_W = $clog2(DIV_HI);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             scaled;

  always_comb begin
    scaled = (mode_i == M_CAP_LO) || (mode_i == M_CAP_HI);
    lim    = (mode_i == M_CAP_HI) ? PRE_W'(DIV_HI - 1) : PRE_W'(DIV_LO - 1);
    evt_o  = ((mode_i == M_CAP_FALL) && fall_i) ||
             ((mode_i == M_CAP_RISE) && rise_i) ||
             (scaled && rise_i && (pre_q == lim));
  end

  always_ff @(posedge clk) begin
    if (rst || mode_chg_i || !scaled) pre_q <= '0;
    else if (rise_i) pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
  end

  p_pre_bound_r3: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == M_CAP_LO) && !mode_chg_i) |-> (pre_q < PRE_W'(DIV_LO)))
    else $error("prescale count beyond low divider");

  p_pre_clear_r4: assert property (@(posedge clk) disable iff (rst)
    mode_chg_i |=> (pre_q == '0))
    else $error("prescale count not cleared on mode change");
endmodule

// File: rtl/tec_compare.sv
module tec_compare
  import tec_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter bit HAS_SPECIAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       mode_i,
  input  logic             mode_chg_i,
  input  logic [TMR_W-1:0] tmr_i,
  input  logic [TMR_W-1:0] ref_i,
  output logic             match_o,
  output logic             pin_o,
  output logic             tmr_rst_o
);
  fn_e  fn;
  logic eq;
  logic eq_q;
  logic pin_q;

  always_comb begin
    fn      = mode_fn(mode_i);
    eq      = (tmr_i == ref_i);
    match_o = (fn == FN_CMP) && eq && !eq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  always_ff @(posedge clk) begin
    if (rst || (fn == FN_OFF)) pin_q <= 1'b0;
    else if (mode_chg_i && (mode_i == M_CMP_SET)) pin_q <= 1'b0;
    else if (mode_chg_i && (mode_i == M_CMP_CLR)) pin_q <= 1'b1;
    else if (match_o) begin
      case (mode_i)
        M_CMP_TOG: pin_q <= ~pin_q;
        M_CMP_SET: pin_q <= 1'b1;
        M_CMP_CLR: pin_q <= 1'b0;
        default:   pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;

  generate
    if (HAS_SPECIAL) begin : g_evt
      logic rst_q;
      always_ff @(posedge clk) begin
        if (rst) rst_q <= 1'b0;
        else     rst_q <= match_o && (mode_i == M_CMP_EVT);
      end
      assign tmr_rst_o = rst_q;

      p_evt_mode_r8: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> ($past(mode_i) == M_CMP_EVT))
        else $error("timer reset outside special mode");
    end else begin : g_no_evt
      assign tmr_rst_o = 1'b0;
    end
  endgenerate

  p_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    (match_o && (mode_i == M_CMP_TOG) && !mode_chg_i) |=> (pin_o != $past(pin_o)))
    else $error("toggle match did not change pin");

  p_force_r7: assert property (@(posedge clk) disable iff (rst)
    (match_o && (mode_i == M_CMP_SET) && !mode_chg_i) |=> pin_o)
    else $error("set-on-match left pin low");
endmodule

// File: rtl/tec_pwm.sv
module tec_pwm #(
  parameter int TB_W   = 8,
  parameter int FINE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en_i,
  input  logic                   per_i,
  input  logic [TB_W-1:0]        tb_i,
  input  logic [TB_W+FINE_W-1:0] duty_i,
  output logic                   pin_o
);
  localparam int D_W = TB_W + FINE_W;

  logic [FINE_W-1:0] fine_q;
  logic [D_W-1:0]    shadow_q;
  logic              pin_q;
  logic [D_W:0]      pos_nx;

  assign pos_nx = {1'b0, tb_i, fine_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      fine_q   <= '0;
      shadow_q <= '0;
      pin_q    <= 1'b0;
    end else if (per_i) begin
      fine_q   <= '0;
      shadow_q <= duty_i;
      pin_q    <= (duty_i != '0);
    end else begin
      fine_q <= fine_q + 1'b1;
      if (pos_nx == {1'b0, shadow_q}) pin_q <= 1'b0;
    end
  end

  assign pin_o = pin_q;

  p_zero_duty_r9: assert property (@(posedge clk) disable iff (rst)
    (en_i && per_i && (duty_i == '0)) |=> !pin_o)
    else $error("zero duty drove pin high");
endmodule

// File: rtl/tmr_event_channel.sv
module tmr_event_channel
  import tec_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 16,
  parameter bit HAS_SPECIAL = 1'b1,
  localparam int BUS_W      = 8,
  localparam int NBYTES     = TMR_W / BUS_W,
  localparam int ADDR_W     = $clog2(2 + NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TMR_W-1:0]  tmr_i,
  input  logic [BUS_W-1:0]  tb_i,
  input  logic              per_i,
  input  logic              pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BUS_W-1:0]  rd_data_o,
  input  logic              flag_clr_i,
  output logic              pin_o,
  output logic              flag_o,
  output logic              tmr_rst_o
);
  localparam int FINE_W = 2;
  localparam int CTRL_W = 4 + FINE_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(1);

  logic [CTRL_W-1:0] ctrl_q;
  logic [BUS_W-1:0]  duty_q;
  logic [TMR_W-1:0]  data_q;
  logic [3:0]        mode;
  logic [3:0]        mode_prev_q;
  logic              mode_chg;
  fn_e               fn;
  logic              rise, fall;
  logic              cap_evt, cmp_match;
  logic              cmp_pin, pwm_pin;
  logic              flag_q;
  logic [BUS_W-1:0]  rd_mux;
  logic [BUS_W-1:0]  rd_q;

  assign mode     = ctrl_q[3:0];
  assign fn       = mode_fn(mode);
  assign mode_chg = (mode != mode_prev_q);

  always_ff @(posedge clk) begin
    if (rst) mode_prev_q <= '0;
    else     mode_prev_q <= mode;
  end

  // control and duty registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      duty_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL) ctrl_q <= wr_data_i[CTRL_W-1:0];
      if (wr_addr_i == A_DUTY) duty_q <= wr_data_i;
    end
  end

  // data register: bus bytes, overridden by a capture in the same cycle
  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_en_i && (wr_addr_i == ADDR_W'(2 + b)))
          data_q[b*BUS_W +: BUS_W] <= wr_data_i;
      end
      if (cap_evt) data_q <= tmr_i;
    end
  end

  tec_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  tec_capture #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_cap (
    .clk(clk), .rst(rst), .mode_i(mode), .mode_chg_i(mode_chg),
    .rise_i(rise), .fall_i(fall), .evt_o(cap_evt)
  );

  tec_compare #(.TMR_W(TMR_W), .HAS_SPECIAL(HAS_SPECIAL)) u_cmp (
    .clk(clk), .rst(rst), .mode_i(mode), .mode_chg_i(mode_chg),
    .tmr_i(tmr_i), .ref_i(data_q), .match_o(cmp_match),
    .pin_o(cmp_pin), .tmr_rst_o(tmr_rst_o)
  );

  tec_pwm #(.TB_W(BUS_W), .FINE_W(FINE_W)) u_pwm (
    .clk(clk), .rst(rst), .en_i(fn == FN_PWM), .per_i(per_i), .tb_i(tb_i),
    .duty_i({duty_q, ctrl_q[CTRL_W-1:4]}), .pin_o(pwm_pin)
  );

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else if (cap_evt || cmp_match) flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == A_CTRL) rd_mux = BUS_W'(ctrl_q);
    if (rd_addr_i == A_DUTY) rd_mux = duty_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (rd_addr_i == ADDR_W'(2 + b)) rd_mux = data_q[b*BUS_W +: BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;
  assign flag_o    = flag_q;
  assign pin_o     = (fn == FN_PWM) ? pwm_pin : cmp_pin;

  p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
    (cap_evt || cmp_match) |=> flag_o)
    else $error("event did not raise flag");

  p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr_i) == A_CTRL) |-> (rd_data_o[7:6] == 2'b00))
    else $error("unimplemented control bits read nonzero");

  p_off_pin_r11: assert property (@(posedge clk) disable iff (rst)
    ((fn == FN_OFF) && $past(fn == FN_OFF)) |-> !pin_o)
    else $error("pin high while disabled");
endmodule

// File: tb/tmr_event_channel_tb_top.sv
module tmr_event_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tmr = '0;
  logic [7:0]  tb = '0;
  logic        per = 1'b0;
  logic        pin_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data, rd_ns;
  logic        flag_clr = 1'b0;
  logic        pin_out, flag, tmr_rst;
  logic        pin_ns, flag_ns, rst_ns;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string req; } exp_t;
  exp_t rq[$];
  logic rd_go = 1'b0;
  logic rd_go_q = 1'b0;

  always #10 clk = ~clk;

  tmr_event_channel dut_i (
    .clk(clk), .rst(rst), .tmr_i(tmr), .tb_i(tb), .per_i(per), .pin_i(pin_in),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .flag_clr_i(flag_clr),
    .pin_o(pin_out), .flag_o(flag), .tmr_rst_o(tmr_rst)
  );

  tmr_event_channel #(.HAS_SPECIAL(1'b0)) dut_ns_i (
    .clk(clk), .rst(rst), .tmr_i(tmr), .tb_i(tb), .per_i(per), .pin_i(pin_in),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_ns), .flag_clr_i(flag_clr),
    .pin_o(pin_ns), .flag_o(flag_ns), .tmr_rst_o(rst_ns)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor for register reads
  always @(posedge clk) rd_go_q <= rd_go;
  always @(negedge clk) begin
    if (rd_go_q) begin
      if (rq.size() == 0) check("R2", "unexpected read", 1, 0);
      else begin
        exp_t e;
        e = rq.pop_front();
        check(e.req, "read data", int'(rd_data), int'(e.exp));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string req);
    exp_t item;
    item.exp = e; item.req = req;
    rq.push_back(item);
    rd_addr = a; rd_go = 1'b1;
    @(negedge clk);
    rd_go = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    pin_in = 1'b1; tick(hi);
    pin_in = 1'b0; tick(lo);
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; tick(1);
    flag_clr = 1'b0; tick(1);
  endtask

  // one timebase period of len clocks; optional duty write in the middle
  task automatic pwm_period(input int len, input int exp, input string req,
                            input bit mid, input logic [7:0] mid_duty);
    int cnt = 0;
    per = 1'b1; tb = 8'd0;
    @(negedge clk);
    per = 1'b0;
    for (int c = 0; c < len; c++) begin
      tb = 8'(c >> 2);
      if (pin_out) cnt++;
      if (mid && c == 2) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = mid_duty; end
      if (c == 3) wr_en = 1'b0;
      @(negedge clk);
    end
    check(req, "pwm high clocks", cnt, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    tick(3); rst = 1'b0; tick(1);

    // R1 reset state
    rd(2'd0, 8'h00, "R1"); rd(2'd1, 8'h00, "R1");
    rd(2'd2, 8'h00, "R1"); rd(2'd3, 8'h00, "R1");
    check("R1", "pin", pin_out, 0); check("R1", "flag", flag, 0);
    check("R1", "tmr_rst", tmr_rst, 0);

    // R2 register map
    wr(2'd0, 8'hFF); rd(2'd0, 8'h3F, "R2");
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hA5); rd(2'd1, 8'hA5, "R2");
    wr(2'd2, 8'h34); wr(2'd3, 8'h12);
    rd(2'd2, 8'h34, "R2"); rd(2'd3, 8'h12, "R2");

    // R3/R5 rising-edge capture
    tmr = 16'hBEEF; wr(2'd0, 8'h05); tick(2);
    pulse(3, 3); tick(3);
    rd(2'd2, 8'hEF, "R5"); rd(2'd3, 8'hBE, "R5");
    check("R5", "flag after capture", flag, 1);
    clr_flag(); check("R5", "flag after clear", flag, 0);

    // R3 falling-edge capture ignores rising edges
    tmr = 16'h1111; wr(2'd0, 8'h04); tick(2);
    pin_in = 1'b1; tick(5);
    check("R3", "flag on rise in falling mode", flag, 0);
    rd(2'd2, 8'hEF, "R3");
    pin_in = 1'b0; tick(5);
    rd(2'd2, 8'h11, "R3"); check("R3", "flag on fall", flag, 1);
    clr_flag();

    // R3 every 4th rising edge
    tmr = 16'h2222; wr(2'd0, 8'h06); tick(2);
    for (int i = 0; i < 3; i++) pulse(2, 2);
    tick(2);
    check("R3", "flag after 3 of 4", flag, 0); rd(2'd2, 8'h11, "R3");
    pulse(2, 2); tick(3);
    rd(2'd2, 8'h22, "R3"); check("R3", "flag after 4th", flag, 1);
    clr_flag();

    // R4 prescaler restarts on mode change
    tmr = 16'h3333;
    pulse(2, 2); pulse(2, 2);
    wr(2'd0, 8'h07); wr(2'd0, 8'h06); tick(2);
    for (int i = 0; i < 3; i++) pulse(2, 2);
    tick(2);
    check("R4", "flag after restart", flag, 0); rd(2'd2, 8'h22, "R4");
    pulse(2, 2); tick(3);
    rd(2'd2, 8'h33, "R4"); clr_flag();

    // R3 every 16th rising edge
    tmr = 16'h4444; wr(2'd0, 8'h07); tick(2);
    for (int i = 0; i < 15; i++) pulse(2, 2);
    tick(2);
    check("R3", "flag after 15 of 16", flag, 0);
    pulse(2, 2); tick(3);
    rd(2'd3, 8'h44, "R3"); clr_flag();

    // R7 set and clear on match
    wr(2'd2, 8'h40); wr(2'd3, 8'h00); tmr = 16'h0000;
    wr(2'd0, 8'h08); tick(2);
    check("R7", "pin on entering 1000", pin_out, 0);
    tmr = 16'h0040; tick(1);
    check("R7", "pin after match 1000", pin_out, 1);
    check("R7", "flag after match 1000", flag, 1);
    clr_flag();
    tmr = 16'h0000; wr(2'd0, 8'h09); tick(2);
    check("R7", "pin on entering 1001", pin_out, 1);
    tmr = 16'h0040; tick(1);
    check("R7", "pin after match 1001", pin_out, 0);
    clr_flag();

    // R6 toggle, stalled timer does not retrigger
    tmr = 16'h0000; wr(2'd0, 8'h02); tick(2);
    tmr = 16'h0040; tick(5);
    check("R6", "single toggle while stalled", pin_out, 1);
    clr_flag(); tick(3);
    check("R6", "no flag while stalled", flag, 0);
    tmr = 16'h0041; tick(1); tmr = 16'h0040; tick(1);
    check("R6", "second toggle", pin_out, 0);
    tmr = 16'h0041; tick(1); tmr = 16'h0040; tick(1);
    check("R6", "third toggle", pin_out, 1);
    clr_flag();

    // R8 flag-only and special event
    wr(2'd0, 8'h0A); tmr = 16'h0000; tick(1);
    tmr = 16'h0040; tick(1);
    check("R8", "flag in 1010", flag, 1);
    check("R8", "pin kept in 1010", pin_out, 1);
    check("R8", "no reset strobe in 1010", tmr_rst, 0);
    clr_flag();
    tmr = 16'h0000; wr(2'd0, 8'h0B); tick(1);
    tmr = 16'h0040; tick(1);
    check("R8", "reset strobe with special", tmr_rst, 1);
    check("R8", "reset strobe without special", rst_ns, 0);
    check("R8", "flag without special", flag_ns, 1);
    check("R8", "pin kept in 1011", pin_out, 1);
    tick(1);
    check("R8", "reset strobe one clock", tmr_rst, 0);
    clr_flag();

    // R11 reserved codes disable
    tmr = 16'h0000; wr(2'd0, 8'h09); tick(2);
    check("R11", "pin high before disable", pin_out, 1);
    wr(2'd0, 8'h03); tick(2);
    check("R11", "pin low in 0011", pin_out, 0);
    tmr = 16'h0040; tick(2);
    check("R11", "no flag in 0011", flag, 0);
    tmr = 16'h0000; wr(2'd0, 8'h09); tick(2);
    wr(2'd0, 8'h01); tick(2);
    check("R11", "pin low in 0001", pin_out, 0);

    // R9/R10 pulse width
    wr(2'd1, 8'h02); wr(2'd0, 8'h1C); tick(2);
    pwm_period(40, 9, "R9", 1'b0, 8'h00);
    pwm_period(40, 9, "R10", 1'b1, 8'h05);
    pwm_period(40, 21, "R10", 1'b0, 8'h00);
    wr(2'd1, 8'h00); wr(2'd0, 8'h0C); tick(1);
    pwm_period(40, 0, "R9", 1'b0, 8'h00);
    wr(2'd1, 8'hFF); wr(2'd0, 8'h3F); tick(1);
    pwm_period(40, 40, "R9", 1'b0, 8'h00);
    wr(2'd0, 8'h00); tick(2);
    check("R11", "pin low in 0000", pin_out, 0);

    tick(2);
    check("R2", "scoreboard drained", rq.size(), 0);
    finish_run();
  end
endmodule